// File: doc/BRIEF.md
# FIFO Reset Sequencer

This controller owns the reset line of a dual-clock FIFO and decides when the FIFO may be used. It runs on the slower of the FIFO's two clocks. Two level inputs report whether the write-side clock and the read-side clock are currently running and stable. The controller issues a FIFO reset only while both clocks are reported good. It holds that reset for a fixed minimum number of slow-clock cycles, then waits through a guard interval before it declares the FIFO usable. Until that point, the user's write and read enables are blocked from reaching the FIFO.

The clock-good inputs come from other clock domains, so each one passes through its own flop synchronizer first. Whenever either synchronized indication drops, the controller returns to waiting and later runs the whole sequence again. A one-cycle restart request lets the system re-run the sequence on demand once the FIFO is usable.

The sequencer has four named states. The edges between them are:

- **IDLE_WAIT to PULSE, "clocks-up":** when both clocks are good.
- **PULSE to GUARD, "pulse-done":** when the pulse count runs out.
- **GUARD to OPEN, "guard-done":** when the guard count runs out.
- **PULSE, GUARD or OPEN to IDLE_WAIT, "clock-lost":** when either clock is lost.
- **OPEN to PULSE, "restart":** on a restart request.

PULSE and GUARD share one down-counter.

Top module: `fifo_rst_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `fifo_rst`, `fifo_ready`, `fifo_wr_en` and `fifo_rd_en` are all 0.
- R2: `fifo_rst` is never driven high unless both synchronized clock-good indications are 1. With the default 2-stage synchronizer, `fifo_rst` rises on the third rising clock edge after both `wclk_good` and `rclk_good` are high.
- R3: A reset pulse that no clock loss interrupts is high for exactly `PULSE_CYCLES` consecutive cycles (default 8).
- R4: `fifo_ready` rises exactly `GUARD_CYCLES` cycles (default 60) after `fifo_rst` falls at the end of a completed pulse. During the guard interval, `fifo_rst` and `fifo_ready` are both 0.
- R5: `fifo_wr_en` and `fifo_rd_en` are 0 while `fifo_ready` is 0. While `fifo_ready` is 1, they equal `user_wr_en` and `user_rd_en`.
- R6: If either clock-good input drops during the pulse, the guard interval or the open state, the controller returns to IDLE_WAIT. `fifo_rst` and `fifo_ready` then go low on the third rising edge after the drop, which cuts short any pulse in progress. Once both inputs are good again, a complete new pulse and guard interval follow.
- R7: A `restart_req` seen in the open state drops `fifo_ready` and raises `fifo_rst` at the next rising edge, and a full pulse and guard interval follow. A `restart_req` in any other state has no effect.
- R8: The shared counter is never decremented while it is already at zero, and it never holds a value above its largest load value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock (the slower of the FIFO write/read clocks) |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| wclk_good | input | 1 | Write-side clock is running and stable (asynchronous) |
| rclk_good | input | 1 | Read-side clock is running and stable (asynchronous) |
| restart_req | input | 1 | Request to re-run the reset sequence (honoured only in OPEN) |
| user_wr_en | input | 1 | User write enable |
| user_rd_en | input | 1 | User read enable |
| fifo_rst | output | 1 | Reset to the FIFO, active high |
| fifo_wr_en | output | 1 | Gated write enable to the FIFO |
| fifo_rd_en | output | 1 | Gated read enable to the FIFO |
| fifo_ready | output | 1 | FIFO may be accessed |

## Verification
The bench builds the block with its defaults: an 8-cycle pulse, a 60-cycle guard interval and 2 synchronizer stages. These values are short enough that every pulse width and guard count is measured cycle-exactly, many times in one run. A scoreboard queue holds the expected width of every reset pulse, including a pulse cut down to 5 cycles by a clock loss. With 2 stages, the three-edge latency from a clock-good change to the controller's reaction is a fixed value the bench can predict for both rising and falling changes.

// File: rtl/fifo_rst_seq_pkg.sv
package fifo_rst_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE_WAIT = 2'd0,
        SQ_PULSE     = 2'd1,
        SQ_GUARD     = 2'd2,
        SQ_OPEN      = 2'd3
    } sq_state_e;

    function automatic int unsigned sq_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fifo_rst_seq_sync.sv
module fifo_rst_seq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= 1'b0;
                else        chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/fifo_rst_seq_cnt.sv
module fifo_rst_seq_cnt #(
    parameter int unsigned W      = 6,
    parameter int unsigned MAXVAL = 59
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R8: the state machine never asks for a decrement at zero
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !zero);

    // R8: counter stays within its largest load value
    a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= W'(MAXVAL));
endmodule

// File: rtl/fifo_rst_seq_fsm.sv
module fifo_rst_seq_fsm
    import fifo_rst_seq_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 8,
    parameter int unsigned GUARD_CYCLES = 60,
    parameter int unsigned CNT_W        = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             both_good,
    input  logic             restart_req,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_load_val,
    output logic             cnt_dec,
    output logic             fifo_rst,
    output logic             fifo_ready
);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYCLES - 1);
    localparam logic [CNT_W-1:0] GUARD_LD = CNT_W'(GUARD_CYCLES - 1);

    sq_state_e st, st_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SQ_IDLE_WAIT;
        else        st <= st_nxt;
    end

    // transitions and counter control
    always_comb begin
        st_nxt       = st;
        cnt_load     = 1'b0;
        cnt_load_val = '0;
        cnt_dec      = 1'b0;
        unique case (st)
            SQ_IDLE_WAIT: begin
                if (both_good) begin                 // clocks-up
                    st_nxt       = SQ_PULSE;
                    cnt_load     = 1'b1;
                    cnt_load_val = PULSE_LD;
                end
            end
            SQ_PULSE: begin
                if (!both_good) begin                // clock-lost
                    st_nxt = SQ_IDLE_WAIT;
                end else if (cnt_zero) begin         // pulse-done
                    st_nxt       = SQ_GUARD;
                    cnt_load     = 1'b1;
                    cnt_load_val = GUARD_LD;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            SQ_GUARD: begin
                if (!both_good) begin                // clock-lost
                    st_nxt = SQ_IDLE_WAIT;
                end else if (cnt_zero) begin         // guard-done
                    st_nxt = SQ_OPEN;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            SQ_OPEN: begin
                if (!both_good) begin                // clock-lost
                    st_nxt = SQ_IDLE_WAIT;
                end else if (restart_req) begin      // restart
                    st_nxt       = SQ_PULSE;
                    cnt_load     = 1'b1;
                    cnt_load_val = PULSE_LD;
                end
            end
            default: st_nxt = SQ_IDLE_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        fifo_rst   = 1'b0;
        fifo_ready = 1'b0;
        unique case (st)
            SQ_PULSE: fifo_rst   = 1'b1;
            SQ_OPEN:  fifo_ready = 1'b1;
            default: ;
        endcase
    end

    // checker-side run-length counters for pulse and guard
    logic [15:0] pulse_run;
    logic [15:0] guard_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_run <= '0;
            guard_run <= '0;
        end else begin
            pulse_run <= fifo_rst ? pulse_run + 16'd1 : 16'd0;
            guard_run <= (st == SQ_GUARD) ? guard_run + 16'd1 : 16'd0;
        end
    end

    a_r2_rst_needs_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_rst) |-> $past(both_good));

    a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fifo_rst) && $past(both_good)) |-> pulse_run == 16'(PULSE_CYCLES));

    a_r4_guard_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_ready) |-> guard_run == 16'(GUARD_CYCLES));

    a_r6_clock_lost: assert property (@(posedge clk) disable iff (!rst_n)
        !both_good |=> (!fifo_rst && !fifo_ready));

    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ready && both_good && restart_req) |=> (fifo_rst && !fifo_ready));
endmodule

// File: rtl/fifo_rst_seq.sv
module fifo_rst_seq
    import fifo_rst_seq_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 8,
    parameter int unsigned GUARD_CYCLES = 60,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk_good,
    input  logic rclk_good,
    input  logic restart_req,
    input  logic user_wr_en,
    input  logic user_rd_en,
    output logic fifo_rst,
    output logic fifo_wr_en,
    output logic fifo_rd_en,
    output logic fifo_ready
);
    localparam int unsigned NUM_CLK = 2;
    localparam int unsigned MAXC    = sq_max(PULSE_CYCLES, GUARD_CYCLES);
    localparam int unsigned CNT_W   = (MAXC < 2) ? 1 : $clog2(MAXC);

    logic [NUM_CLK-1:0] good_raw;
    logic [NUM_CLK-1:0] good_sync;
    logic               both_good;
    logic               cnt_load;
    logic [CNT_W-1:0]   cnt_load_val;
    logic               cnt_dec;
    logic               cnt_zero;

    assign good_raw = {rclk_good, wclk_good};

    generate
        for (genvar i = 0; i < NUM_CLK; i++) begin : g_sync
            fifo_rst_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (good_raw[i]),
                .dout (good_sync[i])
            );
        end
    endgenerate

    assign both_good = &good_sync;

    fifo_rst_seq_cnt #(.W(CNT_W), .MAXVAL(MAXC - 1)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_load_val),
        .dec     (cnt_dec),
        .zero    (cnt_zero)
    );

    fifo_rst_seq_fsm #(
        .PULSE_CYCLES(PULSE_CYCLES),
        .GUARD_CYCLES(GUARD_CYCLES),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .both_good   (both_good),
        .restart_req (restart_req),
        .cnt_zero    (cnt_zero),
        .cnt_load    (cnt_load),
        .cnt_load_val(cnt_load_val),
        .cnt_dec     (cnt_dec),
        .fifo_rst    (fifo_rst),
        .fifo_ready  (fifo_ready)
    );

    assign fifo_wr_en = user_wr_en & fifo_ready;
    assign fifo_rd_en = user_rd_en & fifo_ready;

    // R5: no enable reaches the FIFO without ready and a user request
    a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_en || fifo_rd_en) |-> fifo_ready);
endmodule

// File: tb/sim_fifo_rst_seq.sv
module sim_fifo_rst_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wclk_good = 1'b0, rclk_good = 1'b0, restart_req = 1'b0;
    logic user_wr_en = 1'b0, user_rd_en = 1'b0;
    logic fifo_rst, fifo_wr_en, fifo_rd_en, fifo_ready;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    int exp_q[$];
    int run = 0;

    always #4 clk = ~clk;   // 125 MHz

    fifo_rst_seq #(.PULSE_CYCLES(8), .GUARD_CYCLES(60), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .wclk_good(wclk_good), .rclk_good(rclk_good),
        .restart_req(restart_req), .user_wr_en(user_wr_en), .user_rd_en(user_rd_en),
        .fifo_rst(fifo_rst), .fifo_wr_en(fifo_wr_en), .fifo_rd_en(fifo_rd_en),
        .fifo_ready(fifo_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // monitor: measures each reset pulse and compares against the queue
    always @(negedge clk) begin
        if (fifo_rst === 1'b1) begin
            run++;
        end else if (run > 0) begin
            if (exp_q.size() == 0) check(1'b0, "R3 unexpected pulse", run, 0);
            else begin
                automatic int e = exp_q.pop_front();
                check(run == e, "R3/R6 pulse width", run, e);
            end
            run = 0;
        end
    end

    // watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            check(1'b0, "watchdog", cyc, 20000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_rise(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (fifo_rst !== 1'b1 && n < 1000);
    endtask

    task automatic wait_fall();
        int g = 0;
        while (fifo_rst === 1'b1 && g < 1000) begin @(negedge clk); g++; end
    endtask

    // at the first negedge with fifo_rst low: count cycles until ready
    task automatic measure_guard(output int n, input bit poke_restart);
        n = 0;
        while (fifo_ready !== 1'b1 && n < 1000) begin
            if (fifo_rst === 1'b1) check(1'b0, "R4 rst high in guard", 1, 0);
            restart_req = (poke_restart && n == 10);   // R7: ignored in guard
            n++;
            @(negedge clk);
        end
        restart_req = 1'b0;
    endtask

    initial begin
        int n;
        user_wr_en = 1'b1;
        user_rd_en = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(fifo_rst == 0 && fifo_ready == 0, "R1 outputs in reset", fifo_rst + 2*fifo_ready, 0);
        check(fifo_wr_en == 0 && fifo_rd_en == 0, "R1 enables in reset", fifo_wr_en + 2*fifo_rd_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(fifo_rst == 0 && fifo_ready == 0, "R1 after release", fifo_rst + 2*fifo_ready, 0);

        // R2: only one clock good -> no reset
        wclk_good = 1'b1;
        n = 0;
        repeat (10) begin @(negedge clk); if (fifo_rst) n++; end
        check(n == 0, "R2 rst with one clock", n, 0);

        // R2 latency, R3 width, R4 guard, R7 ignored in guard
        exp_q.push_back(8);
        rclk_good = 1'b1;
        wait_rise(n);
        check(n == 3, "R2 rise latency", n, 3);
        check(fifo_wr_en == 0 && fifo_rd_en == 0, "R5 gated in pulse", fifo_wr_en + 2*fifo_rd_en, 0);
        wait_fall();
        measure_guard(n, 1'b1);
        check(n == 60, "R4 guard length (R7 ignored)", n, 60);

        // R5 pass-through
        user_wr_en = 1'b1; user_rd_en = 1'b0; #1;
        check(fifo_wr_en == 1 && fifo_rd_en == 0, "R5 pass wr", fifo_wr_en + 2*fifo_rd_en, 1);
        user_wr_en = 1'b0; user_rd_en = 1'b1; #1;
        check(fifo_wr_en == 0 && fifo_rd_en == 1, "R5 pass rd", fifo_wr_en + 2*fifo_rd_en, 2);

        // R7 restart in OPEN
        @(negedge clk);
        exp_q.push_back(8);
        restart_req = 1'b1;
        @(negedge clk);
        restart_req = 1'b0;
        check(fifo_rst == 1 && fifo_ready == 0, "R7 restart next edge", fifo_rst + 2*fifo_ready, 1);
        #1 check(fifo_rd_en == 0, "R5 gated after restart", fifo_rd_en, 0);
        wait_fall();
        measure_guard(n, 1'b0);
        check(n == 60, "R7 guard after restart", n, 60);

        // R6 loss in OPEN
        rclk_good = 1'b0;
        repeat (2) @(negedge clk);
        check(fifo_ready == 1, "R6 ready before sync", fifo_ready, 1);
        @(negedge clk);
        check(fifo_ready == 0, "R6 ready drop third edge", fifo_ready, 0);
        repeat (5) @(negedge clk);
        check(fifo_rst == 0, "R6 no rst while lost", fifo_rst, 0);

        // R6 loss during pulse: cut to 5 cycles
        exp_q.push_back(5);
        rclk_good = 1'b1;
        wait_rise(n);
        repeat (2) @(negedge clk);
        wclk_good = 1'b0;
        repeat (3) @(negedge clk);
        check(fifo_rst == 0 && fifo_ready == 0, "R6 pulse cut", fifo_rst + 2*fifo_ready, 0);
        repeat (6) @(negedge clk);

        // R6 loss during guard, then full restart
        exp_q.push_back(8);
        wclk_good = 1'b1;
        wait_rise(n);
        wait_fall();
        repeat (20) @(negedge clk);
        rclk_good = 1'b0;
        n = 0;
        repeat (80) begin @(negedge clk); if (fifo_ready || fifo_rst) n++; end
        check(n == 0, "R6 guard abort holds", n, 0);
        exp_q.push_back(8);
        rclk_good = 1'b1;
        wait_rise(n);
        check(n == 3, "R6 restart latency", n, 3);
        wait_fall();
        measure_guard(n, 1'b0);
        check(n == 60, "R6 full guard after loss", n, 60);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 all pulses seen", exp_q.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule